// File: doc/BRIEF.md
# Flash Status Register Read Logic

This block chooses what a 16-bit NOR-style flash interface returns on a read: array data, or an 8-bit status word. The choice is set by commands written on a write strobe. A status-read command selects status output. A completed program, erase or block-lock sequence also selects it, with no further command needed. Any other command selects array data again. The memory array and the embedded program/erase algorithms are outside the block. They reach it only through a busy input and a set of flag inputs, and these form the live status word.

The status word is not read live. It is captured into a snapshot register on defined bus events and held there. In asynchronous reads the capture happens on the first falling edge of chip enable or output enable in a read cycle. In synchronous burst reads it happens when address-valid or chip enable falls. During a burst the captured word repeats for a fixed number of clocks. In asynchronous page reads only page word 0 is valid. All control inputs are active-low and are sampled on `clk`.

The command state machine has five states:
- `RM_ARRAY`: reads return array data.
- `RM_STATUS`: reads return the status snapshot.
- `RM_PGM_WAIT`, `RM_ERS_WAIT`, `RM_LCK_WAIT`: a program, erase or lock setup has been written and the block is waiting for its second write.

Transitions out of `RM_ARRAY` and `RM_STATUS`:
- 0x70 goes to `RM_STATUS`.
- 0x40 or 0x10 goes to `RM_PGM_WAIT`.
- 0x20 goes to `RM_ERS_WAIT`.
- 0x60 goes to `RM_LCK_WAIT`.
- Any other value, including 0xFF, goes to `RM_ARRAY`.

From any of the three wait states, the next write of any value goes to `RM_STATUS`. While the machine is in a wait state, reads return array data.

Top module: `fsr_status_read`

## Requirements
- R1: After reset the block is in array mode (`stat_mode`=0). `dq_valid` is 0 while `ce_n` and `oe_n` are high. An asynchronous read in array mode returns `array_data` with `dq_valid`=1.
- R2: A write of 0x70 sets `stat_mode` to 1 at the clock edge that samples it.
- R3: Each of the following two-write sequences leaves `stat_mode`=1 after its second write, whatever value that second write carries: 0x40 then any value, 0x10 then any value, 0x20 then any value, 0x60 then any value. `stat_mode` is 0 between the two writes.
- R4: In array or status mode, a write of any value that is not 0x70, 0x40, 0x10, 0x20 or 0x60 sets `stat_mode` to 0. This includes 0xFF. After such a write, reads return `array_data`.
- R5: A valid status read returns {8'h00, S}. S[7] is the inverse of `busy`. S[6:1] equal `flag_in[6:1]` when not busy and are 0 when busy; S[6] is the erase-suspend flag. S[0] equals `flag_in[0]`.
- R6: With `burst_mode`=0, the snapshot is captured at the first falling edge of `ce_n` or `oe_n` in a read cycle. A later fall of the other signal in the same cycle does not capture again. A cycle ends when both signals are high, or when either one rises after both have been low.
- R7: Once captured, the status returned by a read does not change while the read continues, even if `busy` or `flag_in` change.
- R8: With `burst_mode`=1, a fall of `adv_n`, or of `ce_n`, captures the snapshot while `ce_n` is low. In status mode the same word is then returned with `dq_valid`=1 for BURST_LEN clocks (default 4), and `dq_valid` is 0 after that.
- R9: In status mode with `burst_mode`=0 and `page_mode`=1, only `page_idx`=0 is valid. For any other index `dq_valid`=0 and `dq_out`=0.
- R10: With `burst_mode`=0, `dq_valid`=0 and `dq_out`=0 whenever either `ce_n` or `oe_n` was high at the last clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address valid, active low |
| burst_mode | input | 1 | 1 = synchronous burst reads, 0 = asynchronous reads |
| page_mode | input | 1 | 1 = asynchronous page reads |
| page_idx | input | 2 | Word index within the page |
| busy | input | 1 | Program/erase in progress |
| flag_in | input | 7 | Live status flags; bit 6 = erase suspended, bit 0 is always passed through |
| array_data | input | 16 | Data word from the array |
| dq_out | output | 16 | Read data |
| dq_valid | output | 1 | `dq_out` holds valid data |
| stat_mode | output | 1 | Reads return status |

## Verification
The in-RTL assertions check the following on every cycle:
- the result of the status, read-array and sequence-completion commands;
- that a status word showing busy has its error bits masked;
- that the upper data byte is zero in status mode;
- that non-zero page words are gated off;
- that the snapshot holds still through an uninterrupted asynchronous read;
- that a burst load raises valid.

The bench's scenarios are the only way to show the rest:
- that only the first of the two enable falls captures;
- that a burst lasts exactly BURST_LEN clocks and is refreshed by a new address-valid pulse;
- that live flag changes during a read are not seen.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    typedef enum logic [2:0] {
        RM_ARRAY,
        RM_STATUS,
        RM_PGM_WAIT,
        RM_ERS_WAIT,
        RM_LCK_WAIT
    } rd_mode_e;

    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] OP_PGM_A   = 8'h40;
    localparam logic [7:0] OP_PGM_B   = 8'h10;
    localparam logic [7:0] OP_ERASE   = 8'h20;
    localparam logic [7:0] OP_LOCK    = 8'h60;
    localparam logic [7:0] OP_RDARRAY = 8'hFF;
endpackage

// File: rtl/fsr_cmd_fsm.sv
module fsr_cmd_fsm
    import fsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_data,
    output logic       stat_sel
);
    rd_mode_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RM_ARRAY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (cmd_wr) begin
            unique case (state_q)
                RM_ARRAY, RM_STATUS: begin
                    if (cmd_data == OP_STATUS)                             state_d = RM_STATUS;
                    else if (cmd_data == OP_PGM_A || cmd_data == OP_PGM_B) state_d = RM_PGM_WAIT;
                    else if (cmd_data == OP_ERASE)                         state_d = RM_ERS_WAIT;
                    else if (cmd_data == OP_LOCK)                          state_d = RM_LCK_WAIT;
                    else                                                   state_d = RM_ARRAY;
                end
                RM_PGM_WAIT, RM_ERS_WAIT, RM_LCK_WAIT: state_d = RM_STATUS;
                default: state_d = RM_ARRAY;
            endcase
        end
    end

    always_comb begin
        stat_sel = (state_q == RM_STATUS);
    end

    // R2
    status_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_data == OP_STATUS && (state_q == RM_ARRAY || state_q == RM_STATUS))
        |=> stat_sel);

    // R3
    seq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (state_q == RM_PGM_WAIT || state_q == RM_ERS_WAIT || state_q == RM_LCK_WAIT))
        |=> stat_sel);

    // R4
    rdarray_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_data == OP_RDARRAY && (state_q == RM_ARRAY || state_q == RM_STATUS))
        |=> !stat_sel);
endmodule

// File: rtl/fsr_snap.sv
module fsr_snap #(
    parameter int SR_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            burst_mode,
    input  logic            ce_n,
    input  logic            oe_n,
    input  logic            adv_n,
    input  logic [SR_W-1:0] live,
    output logic [SR_W-1:0] snap,
    output logic            ce_q,
    output logic            oe_q,
    output logic            sync_cap
);
    logic adv_q, armed_q;
    logic ce_fell, oe_fell, adv_fell, async_cap, cap;
    localparam logic [SR_W-1:0] SNAP_RST = {1'b1, {(SR_W-1){1'b0}}};

    always_comb begin
        ce_fell   = ce_q & ~ce_n;
        oe_fell   = oe_q & ~oe_n;
        adv_fell  = adv_q & ~adv_n;
        async_cap = ~burst_mode & armed_q & (ce_fell | oe_fell);
        sync_cap  = burst_mode & ~ce_n & (ce_fell | adv_fell);
        cap       = async_cap | sync_cap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q    <= 1'b1;
            oe_q    <= 1'b1;
            adv_q   <= 1'b1;
            armed_q <= 1'b1;
            snap    <= SNAP_RST;
        end else begin
            ce_q  <= ce_n;
            oe_q  <= oe_n;
            adv_q <= adv_n;
            if (cap) snap <= live;
            if (async_cap)                                   armed_q <= 1'b0;
            else if (ce_n && oe_n)                           armed_q <= 1'b1;
            else if (!ce_q && !oe_q && (ce_n || oe_n))       armed_q <= 1'b1;
        end
    end

    // R7
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_mode && !ce_q && !oe_q && !ce_n && !oe_n) |=> $stable(snap));

    // R5
    busy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snap[SR_W-1] |-> (snap[SR_W-2:1] == '0));
endmodule

// File: rtl/fsr_burst.sv
module fsr_burst #(
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic active
);
    localparam int CNT_W = $clog2(BURST_LEN + 1);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= CNT_W'(BURST_LEN);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    always_comb active = (cnt_q != '0);

    // R8
    burst_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> active);
endmodule

// File: rtl/fsr_status_read.sv
module fsr_status_read #(
    parameter int DATA_W    = 16,
    parameter int SR_W      = 8,
    parameter int PAGE_W    = 2,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_data,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              adv_n,
    input  logic              burst_mode,
    input  logic              page_mode,
    input  logic [PAGE_W-1:0] page_idx,
    input  logic              busy,
    input  logic [SR_W-2:0]   flag_in,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_valid,
    output logic              stat_mode
);
    logic [SR_W-1:0] live_sr, snap;
    logic ce_q, oe_q, sync_cap, burst_act, rd_open;

    always_comb begin
        live_sr = {~busy, busy ? {(SR_W-2){1'b0}} : flag_in[SR_W-2:1], flag_in[0]};
    end

    fsr_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data), .stat_sel(stat_mode)
    );

    fsr_snap #(.SR_W(SR_W)) u_snap (
        .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .ce_n(ce_n), .oe_n(oe_n),
        .adv_n(adv_n), .live(live_sr), .snap(snap), .ce_q(ce_q), .oe_q(oe_q),
        .sync_cap(sync_cap)
    );

    fsr_burst #(.BURST_LEN(BURST_LEN)) u_burst (
        .clk(clk), .rst_n(rst_n), .load(sync_cap), .active(burst_act)
    );

    always_comb begin
        rd_open  = ~ce_q & ~oe_q;
        dq_valid = 1'b0;
        dq_out   = '0;
        if (stat_mode) begin
            if (burst_mode) dq_valid = burst_act;
            else            dq_valid = rd_open & (~page_mode | (page_idx == '0));
            if (dq_valid) dq_out = {{(DATA_W-SR_W){1'b0}}, snap};
        end else begin
            dq_valid = rd_open;
            if (dq_valid) dq_out = array_data;
        end
    end

    // R5
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_mode |-> (dq_out[DATA_W-1:SR_W] == '0));

    // R9
    page_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_mode && !burst_mode && page_mode && page_idx != '0) |-> !dq_valid);
endmodule

// File: tb/fsr_status_read_tb.sv
module fsr_status_read_tb_top;
    localparam int BL = 4;
    logic clk = 0, rst_n = 0;
    logic cmd_wr = 0; logic [7:0] cmd_data = 0;
    logic ce_n = 1, oe_n = 1, adv_n = 1, burst_mode = 0, page_mode = 0;
    logic [1:0] page_idx = 0;
    logic busy = 0; logic [6:0] flag_in = 0;
    logic [15:0] array_data = 16'hA5C3;
    logic [15:0] dq_out; logic dq_valid, stat_mode;
    int checks = 0, errors = 0;
    bit done = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    fsr_status_read dut_i (.*);

    // behavioural reference model
    int m_mode;            // 0 array, 1 status, 2 waiting for second write
    bit m_ce, m_oe, m_adv, m_arm;
    logic [7:0] m_snap;
    int m_cnt;

    function automatic logic [7:0] live_word();
        logic [7:0] w;
        w[7] = !busy;
        w[6:1] = busy ? 6'd0 : flag_in[6:1];
        w[0] = flag_in[0];
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_ce = 1; m_oe = 1; m_adv = 1; m_arm = 1; m_snap = 8'h80; m_cnt = 0;
        end else begin
            bit a_cap, s_cap;
            if (cmd_wr) begin
                if (m_mode == 2) m_mode = 1;
                else if (cmd_data == 8'h70) m_mode = 1;
                else if (cmd_data inside {8'h40, 8'h10, 8'h20, 8'h60}) m_mode = 2;
                else m_mode = 0;
            end
            a_cap = !burst_mode && m_arm && ((m_ce && !ce_n) || (m_oe && !oe_n));
            s_cap = burst_mode && !ce_n && ((m_ce && !ce_n) || (m_adv && !adv_n));
            if (a_cap || s_cap) m_snap = live_word();
            if (s_cap) m_cnt = BL; else if (m_cnt > 0) m_cnt--;
            if (a_cap) m_arm = 0;
            else if (ce_n && oe_n) m_arm = 1;
            else if (!m_ce && !m_oe && (ce_n || oe_n)) m_arm = 1;
            m_ce = ce_n; m_oe = oe_n; m_adv = adv_n;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [15:0] e_out; bit e_v;
            if (m_mode == 1) begin
                e_v = burst_mode ? (m_cnt > 0) : (!m_ce && !m_oe && (!page_mode || page_idx == 0));
                e_out = e_v ? {8'h00, m_snap} : 16'h0;
            end else begin
                e_v = !m_ce && !m_oe;
                e_out = e_v ? array_data : 16'h0;
            end
            checks++;
            if (dq_out !== e_out || dq_valid !== e_v || stat_mode !== (m_mode == 1)) begin
                errors++;
                $display("FAIL %s model: out=%h v=%b sm=%b exp out=%h v=%b sm=%b",
                         cur_req, dq_out, dq_valid, stat_mode, e_out, e_v, m_mode == 1);
            end
        end
    end

    task automatic cyc(); @(posedge clk); #1; endtask
    task automatic at_neg(); @(negedge clk); endtask

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] v);
        cmd_wr = 1; cmd_data = v; cyc(); cmd_wr = 0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1; cyc(); at_neg();
        cur_req = "R1";
        chk("R1 valid idle", dq_valid, 0);
        chk("R1 mode", stat_mode, 0);
        ce_n = 0; oe_n = 0; cyc(); at_neg();
        chk("R1 array read", dq_out, 16'hA5C3);
        ce_n = 1; oe_n = 1; cyc();

        cur_req = "R2";
        wr(8'h70); at_neg();
        chk("R2 mode", stat_mode, 1);
        cur_req = "R5";
        busy = 0; flag_in = 7'b1000000;
        ce_n = 0; oe_n = 0; cyc(); at_neg();
        chk("R5 suspend word", dq_out, 16'h00C0);
        cur_req = "R7";
        busy = 1; flag_in = 7'h7F; cyc(); cyc(); at_neg();
        chk("R7 held", dq_out, 16'h00C0);
        ce_n = 1; oe_n = 1; cyc(); at_neg();
        cur_req = "R10";
        chk("R10 idle valid", dq_valid, 0);
        chk("R10 idle out", dq_out, 0);

        cur_req = "R6";
        ce_n = 0; cyc(); at_neg();        // capture here: busy word
        busy = 0; flag_in = 7'h02;
        oe_n = 0; cyc(); at_neg();
        chk("R6 first edge", dq_out, 16'h0001);
        oe_n = 1; cyc(); oe_n = 0; cyc(); at_neg();
        chk("R6 new cycle", dq_out, 16'h0082);
        ce_n = 1; oe_n = 1; cyc();

        cur_req = "R4";
        wr(8'hFF); at_neg();
        chk("R4 rdarray mode", stat_mode, 0);
        ce_n = 0; oe_n = 0; array_data = 16'h1357; cyc(); at_neg();
        chk("R4 array data", dq_out, 16'h1357);
        ce_n = 1; oe_n = 1; cyc();

        cur_req = "R3";
        foreach (seq_ops[i]) begin
            wr(seq_ops[i]); at_neg();
            chk("R3 waiting", stat_mode, 0);
            wr(8'h5A); at_neg();
            chk("R3 done", stat_mode, 1);
            cur_req = "R4";
            wr(8'h90); at_neg();
            chk("R4 other cmd", stat_mode, 0);
            cur_req = "R3";
        end

        cur_req = "R9";
        wr(8'h70);
        page_mode = 1; page_idx = 0; busy = 0; flag_in = 7'h00;
        ce_n = 0; oe_n = 0; cyc(); at_neg();
        chk("R9 word0", dq_out, 16'h0080);
        page_idx = 1; #1;
        chk("R9 word1 valid", dq_valid, 0);
        chk("R9 word1 out", dq_out, 0);
        page_idx = 3; cyc(); at_neg();
        chk("R9 word3", dq_valid, 0);
        ce_n = 1; oe_n = 1; page_mode = 0; page_idx = 0; cyc();

        cur_req = "R8";
        burst_mode = 1; cyc();
        ce_n = 0; cyc();                   // ce fall captures 0x80
        flag_in = 7'h10; adv_n = 0; cyc(); adv_n = 1;  // adv fall captures 0x90
        flag_in = 7'h04;
        for (int i = 0; i < BL; i++) begin
            at_neg();
            chk("R8 burst word", dq_out, 16'h0090);
            chk("R8 burst valid", dq_valid, 1);
            cyc();
        end
        at_neg();
        chk("R8 burst end", dq_valid, 0);
        adv_n = 0; cyc(); adv_n = 1; at_neg();
        chk("R8 refresh", dq_out, 16'h0084);
        ce_n = 1; burst_mode = 0; repeat (BL + 1) cyc();

        at_neg();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    logic [7:0] seq_ops [4] = '{8'h40, 8'h10, 8'h20, 8'h60};
endmodule